// File: doc/BRIEF.md
# SCSI Target Information-Phase Sequencer

This block runs the target side of the three short information phases of a SCSI bus: status, message-in and message-out. Software loads a byte count into a size register and writes a command code. If the device is connected, the sequencer drives the phase lines, waits one clock for them to settle, and then moves bytes with a REQ/ACK handshake. The target drives REQ and the initiator answers with ACK. Bytes travel through a local byte FIFO. Software fills the FIFO when the target sends (status, message-in) and empties it when the target receives (message-out).

The FIFO has two stream ports for software. The write port is valid/ready: a byte is taken on a clock edge where `wr_valid_i` and `wr_ready_o` are both high. `wr_ready_o` is low when the FIFO is full or while a message-out run owns the FIFO's write side. The read port is also valid/ready: a byte leaves on an edge where `rd_valid_o` and `rd_ready_i` are both high. `rd_valid_o` is low when the FIFO is empty or while a sending run owns its read side. A held source may keep `wr_valid_i` high across back-pressure cycles.

When the FIFO cannot serve the next byte, the handshake pauses before raising REQ and resumes by itself. The sequencer reports completion and command errors in sticky status bits that are cleared by writing ones. A single interrupt line stays high while any status bit is set.

Top module: `scsi_tgt_phase_engine`

## Requirements
- R1: After reset, the outputs are as follows: `msg_o`, `cd_o`, `io_o`, `req_o` and `db_oe_o` are low, `stat_o` is 0, `irq_o` is low, `busy_o` is low and `wr_ready_o` is high.
- R2: Command code 0x18 (message-in), while connected:
  - it drives the phase lines (msg,cd,io) to 1,1,1;
  - it sends exactly the number of bytes held in the size register, in FIFO order, on `db_o` with `db_oe_o` high;
  - it then sets status bit 0 (done).
- R3: Command code 0x19 (message-out), while connected:
  - it drives the phase lines to 1,1,0;
  - it takes the size-register number of bytes from `db_i`, each on the edge where ACK is seen high;
  - it places them in the FIFO in arrival order and then sets status bit 0.
- R4: Command code 0x17 (status) drives the phase lines to 0,1,1. It sends exactly one byte, the FIFO head, whatever the size register holds, and then sets status bit 0.
- R5: A code of 0x17, 0x18 or 0x19 written while `connected_i` is low does not run. The phase lines and REQ are unchanged, and status bits 1 (command error) and 2 (error group) are set.
- R6: The phase lines settle at least one full clock before the first REQ of a command rises. REQ never rises on the same edge as a phase change.
- R7: Each byte follows the same handshake:
  - REQ stays high until ACK is seen high, then falls;
  - REQ does not rise again while ACK is still high.
- R8: While sending, no REQ is raised while the FIFO is empty. The run waits and continues when software writes more bytes, without aborting.
- R9: While receiving, no REQ is raised while the FIFO is full (default depth 4). The run continues once software reads a byte.
- R10: `irq_o` is high exactly while a status bit is set. A clear write removes only the bits given as ones in the mask, and zero bits in the mask have no effect.
- R11: A command written while a run is in progress is ignored. Any code other than 0x17, 0x18 or 0x19 is ignored: phase and status are unchanged and no run starts.
- R12: A message command whose size register holds 0 sets status bit 0 without raising REQ.
- R13: The software write port is not ready during a message-out run, even when the FIFO has room. The software read port shows no valid byte during a sending run, even when the FIFO holds data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| connected_i | input | 1 | Device is connected to an initiator |
| cmd_wr_i | input | 1 | Command strobe |
| cmd_code_i | input | 8 | Command code |
| size_wr_i | input | 1 | Size register write strobe |
| size_data_i | input | CNT_W | Byte count for message commands |
| stat_clr_i | input | 1 | Status clear strobe |
| stat_clr_mask_i | input | 3 | Write-one-to-clear mask |
| stat_o | output | 3 | Status: bit0 done, bit1 command error, bit2 error group |
| irq_o | output | 1 | Interrupt request |
| busy_o | output | 1 | A command run is in progress |
| wr_valid_i | input | 1 | Software write stream valid |
| wr_data_i | input | 8 | Software write byte |
| wr_ready_o | output | 1 | FIFO accepts a software byte |
| rd_valid_o | output | 1 | FIFO offers a byte to software |
| rd_data_o | output | 8 | FIFO head byte |
| rd_ready_i | input | 1 | Software takes the offered byte |
| msg_o | output | 1 | MSG phase line |
| cd_o | output | 1 | C/D phase line |
| io_o | output | 1 | I/O phase line |
| req_o | output | 1 | REQ, driven by the target |
| ack_i | input | 1 | ACK from the initiator |
| db_o | output | 8 | Data bus out |
| db_oe_o | output | 1 | Data bus output enable |
| db_i | input | 8 | Data bus in |

## Verification
The hardest situations to reach are the flow-control pauses in the middle of a run. A pause must come after some bytes have already moved, with REQ parked low and no abort. The bench reaches these by programming a count larger than the data it makes available. For a send, it writes fewer bytes than the count. For a receive, it lets the initiator fill the four-entry FIFO before software reads anything. It then checks the REQ count and busy flag during the pause and releases the FIFO afterwards. A bench flag that freezes the responding initiator holds the engine in the middle of a byte. In that window the bench checks the stream ports' ownership rules and the rejection of a second command.

// File: rtl/tpe_pkg.sv
package tpe_pkg;
  localparam int DW = 8;
  localparam int ST_W = 3;
  localparam int ST_DONE = 0;
  localparam int ST_CMDERR = 1;
  localparam int ST_GRPERR = 2;

  localparam logic [7:0] CMD_STATUS  = 8'h17;
  localparam logic [7:0] CMD_MSG_IN  = 8'h18;
  localparam logic [7:0] CMD_MSG_OUT = 8'h19;

  typedef enum logic [1:0] {K_NONE, K_STATUS, K_MSGIN, K_MSGOUT} kind_t;

  typedef struct packed {
    logic msg;
    logic cd;
    logic io;
  } phase_t;

  function automatic kind_t decode_cmd(input logic [7:0] code);
    case (code)
      CMD_STATUS:  return K_STATUS;
      CMD_MSG_IN:  return K_MSGIN;
      CMD_MSG_OUT: return K_MSGOUT;
      default:     return K_NONE;
    endcase
  endfunction

  function automatic phase_t phase_of(input kind_t k);
    case (k)
      K_STATUS: return '{msg: 1'b0, cd: 1'b1, io: 1'b1};
      K_MSGIN:  return '{msg: 1'b1, cd: 1'b1, io: 1'b1};
      K_MSGOUT: return '{msg: 1'b1, cd: 1'b1, io: 1'b0};
      default:  return '{msg: 1'b0, cd: 1'b0, io: 1'b0};
    endcase
  endfunction
endpackage

// File: rtl/tpe_fifo.sv
module tpe_fifo #(
  parameter int W = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0] cnt;

  assign full  = (cnt == FULL_CNT);
  assign empty = (cnt == '0);
  assign head  = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |-> pop) else $error("fifo overflow"); // R9
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty) else $error("fifo underflow"); // R8
endmodule

// File: rtl/tpe_status.sv
module tpe_status
  import tpe_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_done,
  input  logic            ev_cmderr,
  input  logic            clr_wr,
  input  logic [ST_W-1:0] clr_mask,
  output logic [ST_W-1:0] stat,
  output logic            irq
);
  logic [ST_W-1:0] set_vec, clr_vec;

  always_comb begin
    set_vec = '0;
    set_vec[ST_DONE]   = ev_done;
    set_vec[ST_CMDERR] = ev_cmderr;
    set_vec[ST_GRPERR] = ev_cmderr;
    clr_vec = clr_wr ? clr_mask : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= (stat & ~clr_vec) | set_vec;
  end

  assign irq = |stat;

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[ST_DONE] && !(clr_wr && clr_mask[ST_DONE])) |=> stat[ST_DONE])
    else $error("done bit lost"); // R10
  AST_ERR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmderr |=> (stat[ST_CMDERR] && stat[ST_GRPERR]))
    else $error("error bits not set"); // R5
endmodule

// File: rtl/tpe_seq.sv
module tpe_seq
  import tpe_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             connected,
  input  logic             cmd_wr,
  input  logic [7:0]       cmd_code,
  input  logic             size_wr,
  input  logic [CNT_W-1:0] size_data,
  input  logic             fifo_full,
  input  logic             fifo_empty,
  input  logic [DW-1:0]    fifo_head,
  input  logic             ack_i,
  input  logic [DW-1:0]    db_i,
  output phase_t           phase,
  output logic             req_o,
  output logic [DW-1:0]    db_o,
  output logic             db_oe,
  output logic             fifo_pop,
  output logic             fifo_push,
  output logic [DW-1:0]    push_data,
  output logic             busy,
  output logic             tx_active,
  output logic             rx_active,
  output logic             ev_done,
  output logic             ev_cmderr
);
  typedef enum logic [1:0] {S_IDLE, S_SETPH, S_XFER} st_t;
  typedef enum logic [1:0] {H_ARM, H_REQ, H_ACKLO} hs_t;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  st_t st;
  hs_t hs;
  kind_t cmd_kind, kind_q;
  logic [CNT_W-1:0] size_q, left_q;
  logic tx_dir, can_go, accept, arm;

  assign cmd_kind = decode_cmd(cmd_code);
  assign tx_dir   = (kind_q != K_MSGOUT);
  assign can_go   = tx_dir ? !fifo_empty : !fifo_full;
  assign accept   = (st == S_IDLE) && cmd_wr && (cmd_kind != K_NONE) && connected;
  assign arm      = (st == S_XFER) && (hs == H_ARM);

  assign ev_cmderr = (st == S_IDLE) && cmd_wr && (cmd_kind != K_NONE) && !connected;
  assign ev_done   = arm && (left_q == '0);
  assign fifo_pop  = arm && (left_q != '0) && tx_dir && !fifo_empty;
  assign fifo_push = (st == S_XFER) && (hs == H_REQ) && ack_i && !tx_dir;
  assign push_data = db_i;
  assign busy      = (st != S_IDLE);
  assign tx_active = busy && tx_dir;
  assign rx_active = busy && !tx_dir;
  assign db_oe     = busy && phase.io;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      hs     <= H_ARM;
      kind_q <= K_NONE;
      phase  <= '0;
      size_q <= '0;
      left_q <= '0;
      req_o  <= 1'b0;
      db_o   <= '0;
    end else begin
      if (size_wr) size_q <= size_data;
      case (st)
        S_IDLE: begin
          hs <= H_ARM;
          if (accept) begin
            kind_q <= cmd_kind;
            phase  <= phase_of(cmd_kind);
            left_q <= (cmd_kind == K_STATUS) ? ONE : size_q;
            st     <= S_SETPH;
          end
        end
        S_SETPH: st <= S_XFER;
        S_XFER: begin
          case (hs)
            H_ARM: begin
              if (left_q == '0) begin
                st <= S_IDLE;
              end else if (can_go) begin
                req_o <= 1'b1;
                if (tx_dir) db_o <= fifo_head;
                hs <= H_REQ;
              end
            end
            H_REQ: begin
              if (ack_i) begin
                req_o  <= 1'b0;
                left_q <= left_q - 1'b1;
                hs     <= H_ACKLO;
              end
            end
            H_ACKLO: if (!ack_i) hs <= H_ARM;
            default: hs <= H_ARM;
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_PHASE_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> $stable(phase)) else $error("REQ with moving phase"); // R6
  AST_REQ_WAITS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_i) |=> req_o) else $error("REQ dropped early"); // R7
  AST_NO_REQ_ACK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ((hs == H_ACKLO) && ack_i) |=> !req_o) else $error("REQ while ACK high"); // R7
  AST_EMPTY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && tx_dir && fifo_empty && !req_o) |=> !req_o) else $error("REQ on empty"); // R8
  AST_FULL_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !tx_dir && fifo_full && !req_o) |=> !req_o) else $error("REQ on full"); // R9
  AST_ERR_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmderr |=> !busy) else $error("run after error"); // R5
endmodule

// File: rtl/scsi_tgt_phase_engine.sv
module scsi_tgt_phase_engine
  import tpe_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             connected_i,
  input  logic             cmd_wr_i,
  input  logic [7:0]       cmd_code_i,
  input  logic             size_wr_i,
  input  logic [CNT_W-1:0] size_data_i,
  input  logic             stat_clr_i,
  input  logic [2:0]       stat_clr_mask_i,
  output logic [2:0]       stat_o,
  output logic             irq_o,
  output logic             busy_o,
  input  logic             wr_valid_i,
  input  logic [7:0]       wr_data_i,
  output logic             wr_ready_o,
  output logic             rd_valid_o,
  output logic [7:0]       rd_data_o,
  input  logic             rd_ready_i,
  output logic             msg_o,
  output logic             cd_o,
  output logic             io_o,
  output logic             req_o,
  input  logic             ack_i,
  output logic [7:0]       db_o,
  output logic             db_oe_o,
  input  logic [7:0]       db_i
);
  logic f_push, f_pop, f_full, f_empty;
  logic [DW-1:0] f_head, f_wdata;
  logic s_pop, s_push, tx_act, rx_act, ev_done, ev_err;
  logic [DW-1:0] s_pdata;
  phase_t ph;

  assign wr_ready_o = !f_full && !rx_act;
  assign rd_valid_o = !f_empty && !tx_act;
  assign rd_data_o  = f_head;
  assign f_push  = rx_act ? s_push  : (wr_valid_i && wr_ready_o);
  assign f_wdata = rx_act ? s_pdata : wr_data_i;
  assign f_pop   = tx_act ? s_pop   : (rd_valid_o && rd_ready_i);
  assign msg_o = ph.msg;
  assign cd_o  = ph.cd;
  assign io_o  = ph.io;

  tpe_fifo #(.W(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(f_push), .push_data(f_wdata),
    .pop(f_pop), .head(f_head), .full(f_full), .empty(f_empty)
  );

  tpe_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .connected(connected_i),
    .cmd_wr(cmd_wr_i), .cmd_code(cmd_code_i),
    .size_wr(size_wr_i), .size_data(size_data_i),
    .fifo_full(f_full), .fifo_empty(f_empty), .fifo_head(f_head),
    .ack_i(ack_i), .db_i(db_i), .phase(ph), .req_o(req_o),
    .db_o(db_o), .db_oe(db_oe_o), .fifo_pop(s_pop), .fifo_push(s_push),
    .push_data(s_pdata), .busy(busy_o), .tx_active(tx_act),
    .rx_active(rx_act), .ev_done(ev_done), .ev_cmderr(ev_err)
  );

  tpe_status u_stat (
    .clk(clk), .rst_n(rst_n), .ev_done(ev_done), .ev_cmderr(ev_err),
    .clr_wr(stat_clr_i), .clr_mask(stat_clr_mask_i),
    .stat(stat_o), .irq(irq_o)
  );

  AST_STREAM_OWNERSHIP: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_act && rd_valid_o) && !(rx_act && wr_ready_o))
    else $error("stream port open during run"); // R13
endmodule

// File: tb/sim_scsi_tgt_phase_engine.sv
module sim_scsi_tgt_phase_engine;
  logic clk = 0, rst_n = 0;
  logic connected_i = 0, cmd_wr_i = 0, size_wr_i = 0, stat_clr_i = 0;
  logic [7:0] cmd_code_i = 0, size_data_i = 0, wr_data_i = 0, db_i = 0;
  logic [2:0] stat_clr_mask_i = 0;
  logic wr_valid_i = 0, rd_ready_i = 0, ack_i = 0;
  logic [2:0] stat_o;
  logic irq_o, busy_o, wr_ready_o, rd_valid_o, msg_o, cd_o, io_o, req_o, db_oe_o;
  logic [7:0] rd_data_o, db_o;

  scsi_tgt_phase_engine u0 (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic finished = 0;
  logic ini_hold = 0;
  logic [7:0] ini_rx [0:63];
  logic [7:0] ini_tx [0:63];
  int ini_rx_n = 0, ini_tx_i = 0;
  int rises = 0;
  logic ph_bad = 0, hs_bad = 0, oe_bad = 0;
  logic req_prev = 0;
  logic [2:0] ph_prev = 0;

  function automatic logic [2:0] exp_phase(input logic [7:0] code);
    case (code)
      8'h17: return 3'b011;
      8'h18: return 3'b111;
      8'h19: return 3'b110;
      default: return 3'b000;
    endcase
  endfunction

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // monitor: REQ rises vs phase stability
  always @(negedge clk) begin
    if (req_o && !req_prev) begin
      rises++;
      if ({msg_o, cd_o, io_o} != ph_prev) ph_bad = 1;
      if (io_o && !db_oe_o) oe_bad = 1;
    end
    req_prev = req_o;
    ph_prev = {msg_o, cd_o, io_o};
  end

  // responding initiator
  initial begin
    forever begin
      @(negedge clk);
      if (req_o && !ack_i && !ini_hold) begin
        repeat ($urandom_range(0, 2)) begin
          @(negedge clk);
          if (!req_o) hs_bad = 1;
        end
        if (io_o) begin ini_rx[ini_rx_n] = db_o; ini_rx_n++; end
        else begin db_i = ini_tx[ini_tx_i]; ini_tx_i++; end
        ack_i = 1;
        @(negedge clk);
        while (req_o) @(negedge clk);
        repeat ($urandom_range(0, 2)) begin
          @(negedge clk);
          if (req_o) hs_bad = 1;
        end
        ack_i = 0;
      end
    end
  end

  task automatic set_size(input int n);
    @(negedge clk); size_wr_i = 1; size_data_i = 8'(n);
    @(negedge clk); size_wr_i = 0;
  endtask

  task automatic issue(input logic [7:0] code);
    @(negedge clk); cmd_wr_i = 1; cmd_code_i = code;
    @(negedge clk); cmd_wr_i = 0;
  endtask

  task automatic clear(input logic [2:0] m);
    @(negedge clk); stat_clr_i = 1; stat_clr_mask_i = m;
    @(negedge clk); stat_clr_i = 0; stat_clr_mask_i = 0;
  endtask

  task automatic cpu_push(input logic [7:0] d);
    @(negedge clk); wr_valid_i = 1; wr_data_i = d;
    while (!wr_ready_o) @(negedge clk);
    @(negedge clk); wr_valid_i = 0;
  endtask

  task automatic cpu_pop(output logic [7:0] d);
    @(negedge clk); rd_ready_i = 1;
    while (!rd_valid_o) @(negedge clk);
    d = rd_data_o;
    @(negedge clk); rd_ready_i = 0;
  endtask

  task automatic wait_done();
    int k = 0;
    while (!stat_o[0] && k < 3000) begin @(negedge clk); k++; end
  endtask

  task automatic ini_reset();
    ini_rx_n = 0; ini_tx_i = 0; ph_bad = 0; hs_bad = 0; oe_bad = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic [7:0] exp_b [0:15];
    int r0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 phase", {msg_o, cd_o, io_o}, 3'b000);
    check("R1 req", req_o, 0);
    check("R1 stat", stat_o, 0);
    check("R1 irq", irq_o, 0);
    check("R1 oe", db_oe_o, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 stat after release", {busy_o, stat_o}, 0);
    check("R1 wr_ready", wr_ready_o, 1);
    connected_i = 1;

    // R2 message-in, 3 bytes
    ini_reset(); r0 = rises;
    set_size(3);
    cpu_push(8'hA1); cpu_push(8'hB2); cpu_push(8'hC3);
    issue(8'h18);
    wait_done();
    check("R2 count", ini_rx_n, 3);
    check("R2 bytes", {ini_rx[0], ini_rx[1], ini_rx[2]}, 24'hA1B2C3);
    check("R2 phase", {msg_o, cd_o, io_o}, exp_phase(8'h18));
    check("R2 done", stat_o, 3'b001);
    check("R2 oe with req", oe_bad, 0);
    check("R10 irq set", irq_o, 1);
    check("R7 req pulses", rises - r0, 3);
    check("R6 phase settled", ph_bad, 0);
    check("R7 handshake", hs_bad, 0);
    clear(3'b001);
    check("R10 irq cleared", {irq_o, stat_o}, 0);

    // R3 message-out, 2 bytes
    ini_reset();
    ini_tx[0] = 8'h5A; ini_tx[1] = 8'hA5;
    set_size(2);
    issue(8'h19);
    wait_done();
    check("R3 phase", {msg_o, cd_o, io_o}, exp_phase(8'h19));
    check("R3 done", stat_o, 3'b001);
    cpu_pop(b); check("R3 byte0", b, 8'h5A);
    cpu_pop(b); check("R3 byte1", b, 8'hA5);
    check("R7 handshake rx", hs_bad, 0);
    clear(3'b001);

    // R4 status: one byte regardless of size register
    ini_reset(); r0 = rises;
    set_size(5);
    cpu_push(8'h02); cpu_push(8'h77);
    issue(8'h17);
    wait_done();
    check("R4 phase", {msg_o, cd_o, io_o}, exp_phase(8'h17));
    check("R4 one req", rises - r0, 1);
    check("R4 byte", ini_rx[0], 8'h02);
    check("R6 status phase", ph_bad, 0);
    cpu_pop(b); check("R4 left in fifo", b, 8'h77);
    clear(3'b001);

    // R12 size zero
    r0 = rises;
    set_size(0);
    issue(8'h18);
    repeat (6) @(negedge clk);
    check("R12 done", stat_o, 3'b001);
    check("R12 no req", rises - r0, 0);
    clear(3'b001);

    // R8 stall on empty
    ini_reset(); r0 = rises;
    set_size(3);
    cpu_push(8'h11);
    issue(8'h18);
    repeat (30) @(negedge clk);
    check("R8 one req while empty", rises - r0, 1);
    check("R8 still busy", {busy_o, stat_o[0]}, 2'b10);
    cpu_push(8'h22); cpu_push(8'h33);
    wait_done();
    check("R8 resumed", {ini_rx[0], ini_rx[1], ini_rx[2]}, 24'h112233);
    check("R8 done", stat_o, 3'b001);
    clear(3'b001);

    // R9 stall on full
    ini_reset(); r0 = rises;
    for (int i = 0; i < 6; i++) ini_tx[i] = 8'(8'h40 + i);
    set_size(6);
    issue(8'h19);
    repeat (40) @(negedge clk);
    check("R9 four reqs until full", rises - r0, 4);
    check("R9 still busy", {busy_o, stat_o[0]}, 2'b10);
    for (int i = 0; i < 6; i++) begin
      cpu_pop(b); check("R9 order", b, 8'(8'h40 + i));
    end
    wait_done();
    check("R9 done", stat_o, 3'b001);
    clear(3'b001);

    // R13 / R11 with frozen initiator
    ini_reset();
    set_size(2);
    cpu_push(8'hE1); cpu_push(8'hE2);
    ini_hold = 1;
    issue(8'h18);
    repeat (8) @(negedge clk);
    check("R13 req parked", req_o, 1);
    check("R13 rd_valid hidden", rd_valid_o, 0);
    issue(8'h19);
    repeat (3) @(negedge clk);
    check("R11 busy cmd ignored", {msg_o, cd_o, io_o}, 3'b111);
    ini_hold = 0;
    wait_done();
    check("R11 run intact", {ini_rx[0], ini_rx[1]}, 16'hE1E2);
    clear(3'b001);
    ini_reset();
    ini_tx[0] = 8'h9C;
    set_size(1);
    ini_hold = 1;
    issue(8'h19);
    repeat (5) @(negedge clk);
    check("R13 wr_ready hidden", wr_ready_o, 0);
    ini_hold = 0;
    wait_done();
    cpu_pop(b); check("R3 single byte", b, 8'h9C);
    clear(3'b001);

    // R5 disconnected, R10 selective clear
    connected_i = 0; r0 = rises;
    issue(8'h17);
    repeat (4) @(negedge clk);
    check("R5 stat", stat_o, 3'b110);
    check("R5 irq", irq_o, 1);
    check("R5 phase kept", {msg_o, cd_o, io_o}, 3'b110);
    check("R5 no req", {busy_o, 8'(rises - r0)}, 0);
    clear(3'b010);
    check("R10 partial", {irq_o, stat_o}, 4'b1100);
    clear(3'b001);
    check("R10 zero bits", stat_o, 3'b100);
    clear(3'b100);
    check("R10 all clear", {irq_o, stat_o}, 0);
    connected_i = 1;

    // R11 unknown code
    issue(8'h05);
    repeat (4) @(negedge clk);
    check("R11 unknown", {busy_o, stat_o, msg_o, cd_o, io_o}, 7'b0000110);

    // random runs
    for (int k = 0; k < 10; k++) begin
      int n;
      logic dir;
      n = $urandom_range(1, 7);
      dir = 1'($urandom % 2);
      ini_reset(); r0 = rises;
      for (int i = 0; i < n; i++) exp_b[i] = 8'($urandom);
      set_size(n);
      if (dir) begin
        fork
          for (int i = 0; i < n; i++) cpu_push(exp_b[i]);
          begin issue(8'h18); wait_done(); end
        join
        for (int i = 0; i < n; i++) check("R2 random byte", ini_rx[i], exp_b[i]);
      end else begin
        for (int i = 0; i < n; i++) ini_tx[i] = exp_b[i];
        fork
          for (int i = 0; i < n; i++) begin
            cpu_pop(b); check("R3 random byte", b, exp_b[i]);
          end
          begin issue(8'h19); wait_done(); end
        join
      end
      check("R7 random reqs", rises - r0, n);
      check("R6 random phase", ph_bad, 0);
      check("R7 random hs", hs_bad, 0);
      check("R2 random done", stat_o, 3'b001);
      clear(3'b001);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule